// File: doc/BRIEF.md
# Set-Associative Data Cache with Elaboration-Time Write Policy

This block sits between a processor-side load/store port and a word-wide next-level memory port. Each word address is split into a tag, a set index and a word offset. The set is the line address modulo the number of sets, and a line may occupy any way of that set. Every line carries a valid bit and, in write-back builds, a dirty bit. A request that hits completes in the same cycle. On a miss the processor is held by `cpu_stall` while the controller moves whole lines over the memory port one word per handshake.

Two parameters select the behaviour. `WRITE_BACK` chooses between the write policies:

- **Write-through:** every store goes to memory, and a store miss does not allocate a line.
- **Write-back:** stores stay in the cache, a store miss allocates and merges, and dirty victims are copied out before the refill.

`REPL` chooses the victim selector: a free-running LFSR, a per-set round-robin pointer, or per-set age counters giving least-recently-used order. In every case an invalid way is used before any valid one.

The processor keeps `cpu_req` and its address and data steady while `cpu_stall` is high. The access completes on the first rising edge at which `cpu_stall` is low.

Top module: `assoc_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_stall` and `mem_req` are low while no request is presented, and the first access to any address misses.
- R2: A read whose set holds a valid line with a matching tag returns that word with `cpu_stall` low in the same cycle, and causes no memory transfer.
- R3: With the default sizes, address bits [1:0] pick the word in the line, bits [3:2] pick the set and bits [9:4] form the tag. Lines whose addresses differ only in the tag share a set, and up to WAYS of them are resident at once.
- R4: A read miss fetches all WORDS words of the line, word offset 0 first and rising, one word per acknowledged transfer. `cpu_stall` stays high until the line is installed, and the held request then hits.
- R5: In write-through mode every store issues exactly one memory write of the same address and data, including repeated stores to one address. A store hit also updates the cached word. A store miss fetches nothing and leaves the line absent.
- R6: In write-through mode no memory write is ever issued except for a processor store; evictions and misses cause no memory writes.
- R7: In write-back mode a store hit completes in one cycle, updates only the cached word, marks the line dirty and causes no memory transfer.
- R8: In write-back mode a store miss fetches the line and then merges the store into it. Memory is not written at that time.
- R9: In write-back mode, evicting a dirty line first writes all its WORDS words back to the evicted line's address; a clean victim is dropped with no memory write.
- R10: When the indexed set has an invalid way, the victim is the lowest-numbered invalid way, whatever the policy.
- R11: With the LRU policy (`REPL` = 2) the victim is the way whose last hit or fill is the oldest in its set.
- R12: With the FIFO policy (`REPL` = 1) the victim is the way filled longest ago in its set; hits do not change that order.
- R13: With the random policy (`REPL` = 0) the victim is chosen by a free-running LFSR, and every read still returns the most recently stored value of its address.
- R14: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged from the cycle a transfer is requested until the cycle `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_req | input | 1 | Processor access request, held until completion |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid in the completing cycle |
| cpu_stall | output | 1 | High while the access cannot complete |
| mem_req | output | 1 | Next-level transfer request |
| mem_we | output | 1 | 1 = transfer is a write |
| mem_addr | output | ADDR_W | Word address of the transfer |
| mem_wdata | output | DATA_W | Write data of the transfer |
| mem_rdata | input | DATA_W | Read data, sampled with `mem_ack` |
| mem_ack | input | 1 | Transfer accepted in this cycle |

## Verification
The assertions check, on every cycle:

- that at most one way matches a lookup;
- that the LRU ages of each set keep a single oldest way;
- that memory requests hold their address and direction until acknowledged;
- that a completed refill makes the held request hit;
- that eviction writes happen only for dirty victims in write-back builds;
- that memory writes come only from processor stores in write-through builds.

Victim order under each policy, the count and order of memory transfers per miss, and the values that reach memory can only be shown by the bench's scenarios. These scenarios sweep every set and word of a small configuration, and compare the observed values against a shadow memory and arithmetic initial contents.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    REPL_RANDOM = 2'd0,
    REPL_FIFO   = 2'd1,
    REPL_LRU    = 2'd2
  } repl_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVICT = 3'd1,
    ST_FILL  = 3'd2,
    ST_WTHRU = 3'd3,
    ST_RESP  = 3'd4
  } state_e;

endpackage

// File: rtl/cache_tags.sv
module cache_tags #(
  parameter int WAYS       = 2,
  parameter int SETS       = 4,
  parameter int TAG_W      = 6,
  parameter bit WRITE_BACK = 1'b1,
  localparam int IDX_W     = $clog2(SETS),
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [WAY_W-1:0] probe_way,
  input  logic             inst_en,
  input  logic [WAY_W-1:0] inst_way,
  input  logic             dirty_en,
  input  logic [WAY_W-1:0] dirty_way,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAYS-1:0]  valid_vec,
  output logic [TAG_W-1:0] probe_tag,
  output logic             probe_dirty
);

  logic [TAG_W-1:0] tag_q   [WAYS][SETS];
  logic [SETS-1:0]  valid_q [WAYS];
  logic [WAYS-1:0]  match_vec;

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_cmp
      assign valid_vec[gw] = valid_q[gw][set_i];
      assign match_vec[gw] = valid_q[gw][set_i] && (tag_q[gw][set_i] == tag_i);
    end
  endgenerate

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit       = |match_vec;
  assign probe_tag = tag_q[probe_way][set_i];

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[inst_way][set_i] <= tag_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) valid_q[w] <= '0;
    end else if (inst_en) begin
      valid_q[inst_way][set_i] <= 1'b1;
    end
  end

  generate
    if (WRITE_BACK) begin : g_dirty
      logic [SETS-1:0] dirty_q [WAYS];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int w = 0; w < WAYS; w++) dirty_q[w] <= '0;
        end else if (inst_en) begin
          dirty_q[inst_way][set_i] <= 1'b0;
        end else if (dirty_en) begin
          dirty_q[dirty_way][set_i] <= 1'b1;
        end
      end
      assign probe_dirty = dirty_q[probe_way][set_i] && valid_q[probe_way][set_i];
    end else begin : g_clean
      assign probe_dirty = 1'b0;
    end
  endgenerate

  // R3: a tag may live in only one way of a set
  p_one_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

endmodule

// File: rtl/cache_data.sv
module cache_data #(
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int DEPTH = 1 << (WAY_W + IDX_W + OFF_W)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [WAY_W-1:0]  w_way,
  input  logic [IDX_W-1:0]  w_set,
  input  logic [OFF_W-1:0]  w_word,
  input  logic [DATA_W-1:0] w_data,
  input  logic [WAY_W-1:0]  r0_way,
  input  logic [IDX_W-1:0]  r0_set,
  input  logic [OFF_W-1:0]  r0_word,
  output logic [DATA_W-1:0] r0_data,
  input  logic [WAY_W-1:0]  r1_way,
  input  logic [IDX_W-1:0]  r1_set,
  input  logic [OFF_W-1:0]  r1_word,
  output logic [DATA_W-1:0] r1_data
);

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[{w_way, w_set, w_word}] <= w_data;
  end

  assign r0_data = store_q[{r0_way, r0_set, r0_word}];
  assign r1_data = store_q[{r1_way, r1_set, r1_word}];

endmodule

// File: rtl/cache_repl.sv
module cache_repl import cache_pkg::*; #(
  parameter int    WAYS  = 2,
  parameter int    SETS  = 4,
  parameter repl_e REPL  = REPL_LRU,
  localparam int   IDX_W = $clog2(SETS),
  localparam int   WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_i,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAY_W-1:0] pick_way
);

  generate
    if (REPL == REPL_RANDOM) begin : g_rand
      logic [7:0] lfsr_q, lfsr_d;
      assign lfsr_d   = {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= 8'h01;
        else        lfsr_q <= lfsr_d;
      end
      assign pick_way = lfsr_q[WAY_W-1:0];
    end else if (REPL == REPL_FIFO) begin : g_fifo
      logic [WAY_W-1:0] ptr_q [SETS];
      logic [WAY_W-1:0] ptr_d;
      assign ptr_d = (ptr_q[set_i] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[set_i] + 1'b1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (fill_en) begin
          ptr_q[set_i] <= ptr_d;
        end
      end
      assign pick_way = ptr_q[set_i];
    end else begin : g_lru
      logic [WAY_W-1:0] age_q [SETS][WAYS];
      logic [WAY_W-1:0] age_d [SETS][WAYS];
      logic [WAYS-1:0]  oldest [SETS];
      logic             upd;
      logic [WAY_W-1:0] upd_way;

      assign upd     = touch_en | fill_en;
      assign upd_way = fill_en ? fill_way : touch_way;

      always_comb begin
        age_d = age_q;
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == upd_way)
            age_d[set_i][w] = '0;
          else if (age_q[set_i][w] < age_q[set_i][upd_way])
            age_d[set_i][w] = age_q[set_i][w] + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
        end else if (upd) begin
          age_q <= age_d;
        end
      end

      always_comb begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            oldest[s][w] = (age_q[s][w] == WAY_W'(WAYS - 1));
      end

      always_comb begin
        pick_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
          if (oldest[set_i][w]) pick_way = WAY_W'(w);
      end

      genvar gs;
      for (gs = 0; gs < SETS; gs++) begin : g_chk
        // R11: the ages of a set always name exactly one least-recent way
        p_lru_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
          $onehot(oldest[gs]));
      end
    end
  endgenerate

endmodule

// File: rtl/assoc_cache.sv
module assoc_cache import cache_pkg::*; #(
  parameter int    ADDR_W     = 10,
  parameter int    DATA_W     = 32,
  parameter int    WORDS      = 4,
  parameter int    SETS       = 4,
  parameter int    WAYS       = 2,
  parameter bit    WRITE_BACK = 1'b1,
  parameter repl_e REPL       = REPL_LRU
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [OFF_W-1:0] a_off;
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  assign a_off = cpu_addr[OFF_W-1:0];
  assign a_idx = cpu_addr[OFF_W +: IDX_W];
  assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  state_e           state_q, state_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic [WAY_W-1:0] vic_q, vic_d;

  logic             hit;
  logic [WAY_W-1:0] hit_way, pick_way, vic_sel, probe_way;
  logic [WAYS-1:0]  way_valid;
  logic [TAG_W-1:0] probe_tag;
  logic             probe_dirty;
  logic             last_word;

  logic              dw_en, fill_wr, inst_en, dirty_en, touch_en;
  logic [WAY_W-1:0]  dw_way;
  logic [OFF_W-1:0]  dw_word;
  logic [DATA_W-1:0] dw_data, evict_data;

  assign last_word = (cnt_q == OFF_W'(WORDS - 1));

  // lowest invalid way first, else the policy's choice
  always_comb begin
    vic_sel = pick_way;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!way_valid[w]) vic_sel = WAY_W'(w);
  end

  assign probe_way = (state_q == ST_IDLE) ? vic_sel : vic_q;

  cache_tags #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)
  ) u_tags (
    .clk(clk), .rst_n(rst_n), .set_i(a_idx), .tag_i(a_tag),
    .probe_way(probe_way), .inst_en(inst_en), .inst_way(vic_q),
    .dirty_en(dirty_en), .dirty_way(hit_way), .hit(hit), .hit_way(hit_way),
    .valid_vec(way_valid), .probe_tag(probe_tag), .probe_dirty(probe_dirty)
  );

  cache_data #(
    .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)
  ) u_data (
    .clk(clk), .we(dw_en), .w_way(dw_way), .w_set(a_idx), .w_word(dw_word),
    .w_data(dw_data), .r0_way(hit_way), .r0_set(a_idx), .r0_word(a_off),
    .r0_data(cpu_rdata), .r1_way(vic_q), .r1_set(a_idx), .r1_word(cnt_q),
    .r1_data(evict_data)
  );

  cache_repl #(
    .WAYS(WAYS), .SETS(SETS), .REPL(REPL)
  ) u_repl (
    .clk(clk), .rst_n(rst_n), .set_i(a_idx), .touch_en(touch_en),
    .touch_way(hit_way), .fill_en(inst_en), .fill_way(vic_q),
    .pick_way(pick_way)
  );

  // next-state and outputs
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    vic_d     = vic_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cpu_addr;
    mem_wdata = cpu_wdata;
    cpu_stall = 1'b1;
    fill_wr   = 1'b0;
    inst_en   = 1'b0;
    dirty_en  = 1'b0;
    touch_en  = 1'b0;
    dw_en     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        cpu_stall = cpu_req && (!hit || (!WRITE_BACK && cpu_we));
        if (cpu_req) begin
          if (!WRITE_BACK && cpu_we) begin
            state_d = ST_WTHRU;
          end else if (!hit) begin
            vic_d   = vic_sel;
            cnt_d   = '0;
            state_d = (WRITE_BACK && probe_dirty) ? ST_EVICT : ST_FILL;
          end else begin
            touch_en = 1'b1;
            if (cpu_we) begin
              dw_en    = 1'b1;
              dirty_en = 1'b1;
            end
          end
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {probe_tag, a_idx, cnt_q};
        mem_wdata = evict_data;
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (last_word) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {a_tag, a_idx, cnt_q};
        if (mem_ack) begin
          fill_wr = 1'b1;
          dw_en   = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          if (last_word) begin
            inst_en = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WTHRU: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          state_d = ST_RESP;
          if (hit) begin
            dw_en    = 1'b1;
            touch_en = 1'b1;
          end
        end
      end
      ST_RESP: begin
        cpu_stall = 1'b0;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign dw_way  = fill_wr ? vic_q     : hit_way;
  assign dw_word = fill_wr ? cnt_q     : a_off;
  assign dw_data = fill_wr ? mem_rdata : cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vic_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vic_q   <= vic_d;
    end
  end

  // R14: a pending transfer keeps its request, address and direction
  p_hold_req_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4: once the last refill word lands, the held request finds its line
  p_refill_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && mem_ack && last_word) |=> (!cpu_req || hit));

  generate
    if (WRITE_BACK) begin : g_wb_chk
      // R9: only a dirty victim is copied out
      p_evict_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT) |-> probe_dirty);
    end else begin : g_wt_chk
      // R6: memory writes come only from processor stores
      p_wt_store_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (cpu_req && cpu_we));
    end
  endgenerate

endmodule

// File: tb/tb_assoc_cache.sv
`timescale 1ns/1ps

module tb_mem (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [9:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        ack,
  output int          rd_cnt,
  output int          wr_cnt,
  output logic        seq_err,
  output logic        hs_err
);
  logic [31:0] mem [1024];
  logic [1:0]  wcnt, rseq;
  logic        hold_q, hwe_q;
  logic [9:0]  haddr_q;

  initial for (int a = 0; a < 1024; a++) mem[a] = a * 7 + 32'h1000;

  assign rdata = mem[addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; wcnt <= '0; rseq <= '0; rd_cnt <= 0; wr_cnt <= 0;
      seq_err <= 1'b0; hs_err <= 1'b0; hold_q <= 1'b0; haddr_q <= '0; hwe_q <= 1'b0;
    end else begin
      if (hold_q && (!req || addr != haddr_q || we != hwe_q)) hs_err <= 1'b1;
      hold_q  <= req && !ack;
      haddr_q <= addr;
      hwe_q   <= we;
      if (req && !ack) begin
        if (wcnt == 2'd1) begin ack <= 1'b1; wcnt <= '0; end
        else wcnt <= wcnt + 1'b1;
      end else begin
        ack <= 1'b0;
      end
      if (req && ack) begin
        if (we) begin
          mem[addr] <= wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          rd_cnt <= rd_cnt + 1;
          if (addr[1:0] != rseq) seq_err <= 1'b1;
          rseq <= rseq + 1'b1;
        end
      end
    end
  end
endmodule

module tb_assoc_cache;
  import cache_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        c_req   [3];
  logic        c_we    [3];
  logic [9:0]  c_addr  [3];
  logic [31:0] c_wdata [3];
  logic [31:0] c_rdata [3];
  logic        c_stall [3];
  logic        m_req   [3];
  logic        m_we    [3];
  logic [9:0]  m_addr  [3];
  logic [31:0] m_wdata [3];
  logic [31:0] m_rdata [3];
  logic        m_ack   [3];
  int          m_rd    [3];
  int          m_wr    [3];
  logic        m_seq   [3];
  logic        m_hs    [3];

  logic [31:0] sh [3][1024];
  int checks = 0;
  int errors = 0;

  assoc_cache #(.WRITE_BACK(1'b1), .REPL(REPL_LRU)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(c_req[0]), .cpu_we(c_we[0]),
    .cpu_addr(c_addr[0]), .cpu_wdata(c_wdata[0]), .cpu_rdata(c_rdata[0]),
    .cpu_stall(c_stall[0]), .mem_req(m_req[0]), .mem_we(m_we[0]),
    .mem_addr(m_addr[0]), .mem_wdata(m_wdata[0]), .mem_rdata(m_rdata[0]),
    .mem_ack(m_ack[0]));

  assoc_cache #(.WRITE_BACK(1'b0), .REPL(REPL_FIFO)) dut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(c_req[1]), .cpu_we(c_we[1]),
    .cpu_addr(c_addr[1]), .cpu_wdata(c_wdata[1]), .cpu_rdata(c_rdata[1]),
    .cpu_stall(c_stall[1]), .mem_req(m_req[1]), .mem_we(m_we[1]),
    .mem_addr(m_addr[1]), .mem_wdata(m_wdata[1]), .mem_rdata(m_rdata[1]),
    .mem_ack(m_ack[1]));

  assoc_cache #(.WRITE_BACK(1'b1), .REPL(REPL_RANDOM)) dut_rnd (
    .clk(clk), .rst_n(rst_n), .cpu_req(c_req[2]), .cpu_we(c_we[2]),
    .cpu_addr(c_addr[2]), .cpu_wdata(c_wdata[2]), .cpu_rdata(c_rdata[2]),
    .cpu_stall(c_stall[2]), .mem_req(m_req[2]), .mem_we(m_we[2]),
    .mem_addr(m_addr[2]), .mem_wdata(m_wdata[2]), .mem_rdata(m_rdata[2]),
    .mem_ack(m_ack[2]));

  tb_mem m0 (.clk(clk), .rst_n(rst_n), .req(m_req[0]), .we(m_we[0]), .addr(m_addr[0]),
    .wdata(m_wdata[0]), .rdata(m_rdata[0]), .ack(m_ack[0]), .rd_cnt(m_rd[0]),
    .wr_cnt(m_wr[0]), .seq_err(m_seq[0]), .hs_err(m_hs[0]));
  tb_mem m1 (.clk(clk), .rst_n(rst_n), .req(m_req[1]), .we(m_we[1]), .addr(m_addr[1]),
    .wdata(m_wdata[1]), .rdata(m_rdata[1]), .ack(m_ack[1]), .rd_cnt(m_rd[1]),
    .wr_cnt(m_wr[1]), .seq_err(m_seq[1]), .hs_err(m_hs[1]));
  tb_mem m2 (.clk(clk), .rst_n(rst_n), .req(m_req[2]), .we(m_we[2]), .addr(m_addr[2]),
    .wdata(m_wdata[2]), .rdata(m_rdata[2]), .ack(m_ack[2]), .rd_cnt(m_rd[2]),
    .wr_cnt(m_wr[2]), .seq_err(m_seq[2]), .hs_err(m_hs[2]));

  function automatic logic [9:0] adr(int t, int s, int o);
    return {6'(t), 2'(s), 2'(o)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input int k, input bit we, input logic [9:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output int cyc);
    @(negedge clk);
    c_req[k] = 1'b1; c_we[k] = we; c_addr[k] = a; c_wdata[k] = wd;
    #1;
    cyc = 0;
    while (c_stall[k] && cyc < 500) begin
      @(negedge clk); #1; cyc++;
    end
    rd = c_rdata[k];
    @(posedge clk); #1;
    c_req[k] = 1'b0; c_we[k] = 1'b0;
    if (we) sh[k][a] = wd;
  endtask

  // read with an expected hit (1), miss (0) or either (2)
  task automatic rd_exp(input int k, input logic [9:0] a, input int mode, input string req);
    logic [31:0] rd;
    int cyc, r0;
    r0 = m_rd[k];
    acc(k, 1'b0, a, '0, rd, cyc);
    check(req, rd, sh[k][a]);
    if (mode == 1) begin
      check({req, " hit-latency"}, cyc, 0);
      check({req, " hit-no-fetch"}, m_rd[k] - r0, 0);
    end else if (mode == 0) begin
      check({req, " miss-stalls"}, (cyc > 0), 1);
      check({req, " miss-fetch-line"}, m_rd[k] - r0, 4);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc, w0, r0;
    for (int k = 0; k < 3; k++) begin
      c_req[k] = 0; c_we[k] = 0; c_addr[k] = '0; c_wdata[k] = '0;
      for (int a = 0; a < 1024; a++) sh[k][a] = a * 7 + 32'h1000;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    for (int k = 0; k < 3; k++) begin
      check("R1 idle stall", c_stall[k], 0);
      check("R1 idle mem_req", m_req[k], 0);
    end

    // cold sweep: two tags per set, then every word of both hits
    for (int k = 0; k < 3; k++) begin
      for (int s = 0; s < 4; s++) begin
        rd_exp(k, adr(1, s, 0), 0, "R1 R4 cold miss tag1");
        rd_exp(k, adr(2, s, 3), 0, "R10 R3 second tag fills free way");
      end
      for (int s = 0; s < 4; s++)
        for (int t = 1; t <= 2; t++)
          for (int o = 0; o < 4; o++)
            rd_exp(k, adr(t, s, o), 1, "R2 R3 resident word hit");
    end

    // R11 LRU order on dut
    w0 = m_wr[0];
    rd_exp(0, adr(1, 0, 0), 1, "R11 touch tag1");
    rd_exp(0, adr(3, 0, 0), 0, "R11 tag3 evicts lru tag2");
    rd_exp(0, adr(1, 0, 1), 1, "R11 tag1 survives");
    rd_exp(0, adr(2, 0, 0), 0, "R11 tag2 was evicted");
    check("R9 clean victims no writeback", m_wr[0] - w0, 0);

    // R7 write-back store hit
    w0 = m_wr[0]; r0 = m_rd[0];
    acc(0, 1'b1, adr(1, 1, 1), 32'hCAFE0001, rd, cyc);
    check("R7 store hit one cycle", cyc, 0);
    check("R7 store hit no mem write", m_wr[0] - w0, 0);
    check("R7 store hit no mem read", m_rd[0] - r0, 0);
    rd_exp(0, adr(1, 1, 1), 1, "R7 store hit visible");
    w0 = m_wr[0];
    rd_exp(0, adr(4, 1, 0), 0, "R9 clean lru tag2 evicted");
    check("R9 clean eviction no write", m_wr[0] - w0, 0);
    w0 = m_wr[0];
    rd_exp(0, adr(6, 1, 0), 0, "R9 dirty tag1 evicted");
    check("R9 dirty line written back", m_wr[0] - w0, 4);
    check("R9 written value in memory", m0.mem[adr(1, 1, 1)], 32'hCAFE0001);
    rd_exp(0, adr(1, 1, 1), 0, "R9 refetch returns stored value");

    // R8 write-back store miss allocates and merges
    w0 = m_wr[0]; r0 = m_rd[0];
    acc(0, 1'b1, adr(7, 2, 2), 32'hBEEF0002, rd, cyc);
    check("R8 store miss stalls", (cyc > 0), 1);
    check("R8 store miss fetches line", m_rd[0] - r0, 4);
    check("R8 store miss no mem write", m_wr[0] - w0, 0);
    rd_exp(0, adr(7, 2, 2), 1, "R8 merged word");
    rd_exp(0, adr(7, 2, 1), 1, "R8 neighbour word from fill");
    check("R8 memory not updated", m0.mem[adr(7, 2, 2)], adr(7, 2, 2) * 7 + 32'h1000);

    // R12 FIFO order on dut_wt
    w0 = m_wr[1];
    rd_exp(1, adr(1, 0, 0), 1, "R12 hit does not reorder");
    rd_exp(1, adr(3, 0, 0), 0, "R12 tag3 evicts oldest tag1");
    rd_exp(1, adr(2, 0, 1), 1, "R12 tag2 survives");
    rd_exp(1, adr(1, 0, 0), 0, "R12 tag1 was evicted");
    check("R6 evictions no mem write", m_wr[1] - w0, 0);

    // R5 write-through stores
    w0 = m_wr[1];
    acc(1, 1'b1, adr(2, 1, 2), 32'h11110001, rd, cyc);
    check("R5 store hit one mem write", m_wr[1] - w0, 1);
    check("R5 store value in memory", m1.mem[adr(2, 1, 2)], 32'h11110001);
    rd_exp(1, adr(2, 1, 2), 1, "R5 store hit updates cache");
    w0 = m_wr[1];
    acc(1, 1'b1, adr(2, 1, 2), 32'h22220002, rd, cyc);
    check("R5 repeated store writes again", m_wr[1] - w0, 1);
    check("R5 repeated value in memory", m1.mem[adr(2, 1, 2)], 32'h22220002);
    w0 = m_wr[1]; r0 = m_rd[1];
    acc(1, 1'b1, adr(5, 2, 0), 32'h33330003, rd, cyc);
    check("R5 store miss one mem write", m_wr[1] - w0, 1);
    check("R5 store miss no fetch", m_rd[1] - r0, 0);
    rd_exp(1, adr(5, 2, 0), 0, "R5 store miss not allocated");
    check("R6 writes equal stores", m_wr[1], 3);

    // R13 random replacement under thrash
    for (int i = 0; i < 8; i++)
      acc(2, 1'b1, adr(8 + i, 3, i % 4), 32'h77000000 + i, rd, cyc);
    for (int i = 0; i < 8; i++)
      rd_exp(2, adr(8 + i, 3, i % 4), 2, "R13 data after random eviction");
    for (int i = 0; i < 8; i++)
      rd_exp(2, adr(8 + i, 3, (i + 1) % 4), 2, "R13 untouched word after eviction");

    for (int k = 0; k < 3; k++) begin
      check("R4 fill order ascending", m_seq[k], 0);
      check("R4 whole-line fetches", m_rd[k] % 4, 0);
      check("R14 request held until ack", m_hs[k], 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule